// File: doc/BRIEF.md
# PRBS Test Pattern Generator

This block produces a serial pseudo-random test pattern for line and link testing. The pattern is one bit per bit strobe. A two-bit select picks one of three maximal-length sequences, with periods 2^11-1, 2^15-1 and 2^20-1. The generator restarts from a fixed all-ones seed whenever the test enable rises. The select value is captured at that moment, so a later change to the select waits for the next restart.

Two manipulations are applied after generation. A transmit-invert level inverts every outgoing bit. A rising edge on the error-insert input flips exactly one outgoing bit, which is the next one produced. The shift register itself is never disturbed, so the sequence resumes correctly on the following bit. While the test enable is low the block is silent: the bit output is 0 and the valid flag is low.

Top module: `prbs_tx_gen`

## Requirements
- R1: The select captured at the last enable rise sets the sequence. 0 selects x^11+x^9+1, 1 selects x^15+x^14+1, and 2 or 3 select x^20+x^17+1. For a length L and a tap T, the raw output bit is register bit L-1. On each advance the register shifts toward higher bits and takes bit(L-1) XOR bit(T-1) into bit 0.
- R2: The cycle in which test_en goes from 0 to 1 loads the register with all ones. That cycle produces no output. The first L bits produced after the rise are therefore all 1 when there is no inversion and no error.
- R3: The register advances only in a cycle with bit_stb high while running, that is, test_en high and not a rise cycle. pat_vld is high in exactly the cycle after such a strobe cycle. pat_bit holds its value until the next produced bit.
- R4: In the cycle after any cycle with test_en low, pat_bit is 0 and pat_vld is 0. Strobes are ignored while test_en is low.
- R5: A change of pat_sel while running has no effect on the sequence until the next rise of test_en.
- R6: A 0-to-1 edge of err_ins while running flips the next produced bit only. This includes a bit produced in the same cycle as the edge. Several edges before one produced bit still give one flip. The register sequence is unaffected. Edges while not running are dropped.
- R7: With tx_inv high in a strobe cycle, the bit produced from that strobe is inverted. Any injected error is XORed on top of the inverted bit.
- R8: With a constant select of 0 or 1, the produced bit stream repeats with period 2047 or 32767 bits respectively.
- R9: The active bits of the shift register are never all zero, so the stream never locks at a constant value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | Produce one pattern bit this cycle |
| pat_sel | input | 2 | Sequence select, captured on test_en rise |
| test_en | input | 1 | Test enable; a rising edge restarts the pattern |
| err_ins | input | 1 | Rising edge injects one bit error |
| tx_inv | input | 1 | Invert the produced bits |
| pat_bit | output | 1 | Serial pattern bit |
| pat_vld | output | 1 | High in the cycle after a produced bit |

## Verification
The assertions check the following on every cycle:
- the silent state after test_en is low;
- that pat_vld is only ever preceded by a strobe while enabled;
- the all-ones seed after a rise;
- the held select between rises;
- the absence of an all-zero register.

Only the bench scenarios can show the exact bit values:
- the polynomial choice;
- the single-bit error that leaves the following bits intact;
- the inversion combined with an error;
- the full sequence periods.

The bench compares these against its own model of the sequences.

// File: rtl/prbs_tx_pkg.sv
package prbs_tx_pkg;

    localparam int PRBS_MAX_W   = 20;
    localparam int PRBS_NUM_VAR = 3;
    localparam int SEL_W        = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_P11  = 2'd0,
        SEL_P15  = 2'd1,
        SEL_P20  = 2'd2,
        SEL_P20B = 2'd3
    } prbs_sel_e;

    // register length of sequence variant v
    function automatic int var_len(input int v);
        case (v)
            0:       return 11;
            1:       return 15;
            default: return 20;
        endcase
    endfunction

    // inner tap of sequence variant v
    function automatic int var_tap(input int v);
        case (v)
            0:       return 9;
            1:       return 14;
            default: return 17;
        endcase
    endfunction

    // variant index for a select code (2 and 3 share the long sequence)
    function automatic logic [1:0] var_of(input prbs_sel_e s);
        case (s)
            SEL_P11: return 2'd0;
            SEL_P15: return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    typedef struct packed {
        logic [PRBS_MAX_W-1:0] state;
    } lfsr_t;

    typedef struct packed {
        logic bit_o;
        logic vld_o;
        logic pend;
    } outst_t;

    typedef struct packed {
        prbs_sel_e sel;
    } ctl_t;

endpackage

// File: rtl/prbs_edge_det.sv
module prbs_edge_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] prev,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
        prev   = prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/prbs_lfsr_core.sv
module prbs_lfsr_core
    import prbs_tx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  adv,
    input  prbs_sel_e             sel,
    output logic [PRBS_MAX_W-1:0] state,
    output logic                  raw_bit
);
    lfsr_t r_d, r_q;
    logic [PRBS_NUM_VAR-1:0] fb_v;
    logic [PRBS_NUM_VAR-1:0] msb_v;
    logic [1:0]              vidx;

    // one feedback / output tap pair per sequence variant
    for (genvar g = 0; g < PRBS_NUM_VAR; g++) begin : g_var
        localparam int LEN = var_len(g);
        localparam int TAP = var_tap(g);
        assign fb_v[g]  = r_q.state[LEN-1] ^ r_q.state[TAP-1];
        assign msb_v[g] = r_q.state[LEN-1];
    end

    always_comb begin
        vidx    = var_of(sel);
        r_d     = r_q;
        raw_bit = msb_v[vidx];
        if (load) begin
            r_d.state = '1;
        end else if (adv) begin
            r_d.state = {r_q.state[PRBS_MAX_W-2:0], fb_v[vidx]};
        end
        state = r_q.state;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q.state <= '1;
        else        r_q       <= r_d;
    end
endmodule

// File: rtl/prbs_out_stage.sv
module prbs_out_stage
    import prbs_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic adv,
    input  logic raw_bit,
    input  logic inv,
    input  logic err_rise,
    output logic bit_o,
    output logic vld_o
);
    outst_t o_d, o_q;
    logic   pend_now;

    always_comb begin
        o_d      = o_q;
        pend_now = o_q.pend | err_rise;
        if (!running) begin
            o_d.bit_o = 1'b0;
            o_d.vld_o = 1'b0;
            o_d.pend  = 1'b0;
        end else if (adv) begin
            o_d.bit_o = raw_bit ^ inv ^ pend_now;
            o_d.vld_o = 1'b1;
            o_d.pend  = 1'b0;
        end else begin
            o_d.vld_o = 1'b0;
            o_d.pend  = pend_now;
        end
        bit_o = o_q.bit_o;
        vld_o = o_q.vld_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end
endmodule

// File: rtl/prbs_tx_gen.sv
module prbs_tx_gen
    import prbs_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_stb,
    input  logic [1:0] pat_sel,
    input  logic       test_en,
    input  logic       err_ins,
    input  logic       tx_inv,
    output logic       pat_bit,
    output logic       pat_vld
);
    localparam int EDGE_W = 2;

    logic [EDGE_W-1:0]     lvl, prev, rise;
    logic                  ten_rise, err_rise, running, adv, raw_bit;
    logic [PRBS_MAX_W-1:0] state;
    ctl_t                  c_d, c_q;

    assign lvl = {err_ins, test_en};

    prbs_edge_det #(.W(EDGE_W)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .prev (prev),
        .rise (rise)
    );

    always_comb begin
        ten_rise = rise[0];
        err_rise = rise[1];
        running  = test_en & prev[0];
        adv      = running & bit_stb;
        c_d      = c_q;
        if (ten_rise) c_d.sel = prbs_sel_e'(pat_sel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q.sel <= SEL_P11;
        else        c_q     <= c_d;
    end

    prbs_lfsr_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ten_rise),
        .adv    (adv),
        .sel    (c_q.sel),
        .state  (state),
        .raw_bit(raw_bit)
    );

    prbs_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .adv     (adv),
        .raw_bit (raw_bit),
        .inv     (tx_inv),
        .err_rise(err_rise),
        .bit_o   (pat_bit),
        .vld_o   (pat_vld)
    );
endmodule

// File: rtl/prbs_tx_gen_chk.sv
module prbs_tx_gen_chk
    import prbs_tx_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  test_en,
    input logic                  bit_stb,
    input logic                  pat_bit,
    input logic                  pat_vld,
    input logic                  ten_rise,
    input logic [PRBS_MAX_W-1:0] state,
    input prbs_sel_e             sel_q
);
    function automatic logic [PRBS_MAX_W-1:0] act_mask(input prbs_sel_e s);
        case (s)
            SEL_P11: return PRBS_MAX_W'((1 << 11) - 1);
            SEL_P15: return PRBS_MAX_W'((1 << 15) - 1);
            default: return '1;
        endcase
    endfunction

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> (!pat_vld && !pat_bit)); // R4

    AST_VLD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        pat_vld |-> ($past(bit_stb) && $past(test_en))); // R3

    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ten_rise |=> (state == '1)); // R2

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !ten_rise |=> $stable(sel_q)); // R5

    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (state & act_mask(sel_q)) != '0); // R9
endmodule

bind prbs_tx_gen prbs_tx_gen_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .test_en (test_en),
    .bit_stb (bit_stb),
    .pat_bit (pat_bit),
    .pat_vld (pat_vld),
    .ten_rise(ten_rise),
    .state   (state),
    .sel_q   (c_q.sel)
);

// File: tb/prbs_tx_gen_test.sv
module prbs_tx_gen_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_stb, test_en, err_ins, tx_inv;
    logic [1:0] pat_sel;
    logic       pat_bit, pat_vld;

    always #4 clk = ~clk;

    prbs_tx_gen uut (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .pat_sel(pat_sel),
        .test_en(test_en), .err_ins(err_ins), .tx_inv(tx_inv),
        .pat_bit(pat_bit), .pat_vld(pat_vld)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R4";

    // bench model
    logic [19:0] m_st = '1;
    logic [1:0]  m_sel = 2'd0;
    logic        m_pten = 0, m_perr = 0, m_pend = 0, m_bit = 0, m_vld = 0;

    function automatic logic m_out(input logic [19:0] s, input logic [1:0] sl);
        case (sl)
            2'd0:    return s[10];
            2'd1:    return s[14];
            default: return s[19];
        endcase
    endfunction

    function automatic logic [19:0] m_next(input logic [19:0] s, input logic [1:0] sl);
        logic fb;
        case (sl)
            2'd0:    fb = s[10] ^ s[8];
            2'd1:    fb = s[14] ^ s[13];
            default: fb = s[19] ^ s[16];
        endcase
        return {s[18:0], fb};
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic step(input logic stb, input logic ten, input logic err,
                        input logic inv, input logic [1:0] sel);
        logic rise, erise;
        bit_stb = stb; test_en = ten; err_ins = err; tx_inv = inv; pat_sel = sel;
        rise  = ten & ~m_pten;
        erise = err & ~m_perr;
        if (!ten || rise) begin
            m_bit = 0; m_vld = 0; m_pend = 0;
            if (rise) begin m_st = '1; m_sel = sel; end
        end else begin
            if (erise) m_pend = 1;
            if (stb) begin
                m_bit  = m_out(m_st, m_sel) ^ inv ^ m_pend;
                m_vld  = 1;
                m_pend = 0;
                m_st   = m_next(m_st, m_sel);
            end else begin
                m_vld = 0;
            end
        end
        m_pten = ten;
        m_perr = err;
        @(posedge clk);
        @(negedge clk);
        chk(tag, "pat_vld", pat_vld, m_vld);
        chk(tag, "pat_bit", pat_bit, m_bit);
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] head;
        int          n;
        int          ones;
        void'($urandom(32'd4242));
        rst_n = 0; bit_stb = 0; test_en = 0; err_ins = 0; tx_inv = 0; pat_sel = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        chk("R4", "reset pat_vld", pat_vld, 1'b0);
        chk("R4", "reset pat_bit", pat_bit, 1'b0);

        // R4: strobes while disabled are ignored
        tag = "R4";
        for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 2'd1);

        // R2: seed, first 11 bits are ones on the short sequence
        tag = "R2";
        step(1, 1, 0, 0, 2'd0);
        for (int i = 0; i < 11; i++) begin
            step(1, 1, 0, 0, 2'd0);
            chk("R2", "seed bit", pat_bit, 1'b1);
        end
        tag = "R1";
        for (int i = 0; i < 200; i++) step(1, 1, 0, 0, 2'd0);

        // R5: select changes mid-run are ignored
        tag = "R5";
        for (int i = 0; i < 100; i++) step(1, 1, 0, 0, 2'($urandom_range(3)));

        // R6: error edge without strobe, then strobe flips exactly one bit
        tag = "R6";
        step(0, 1, 1, 0, 2'd0);
        step(0, 1, 0, 0, 2'd0);
        step(0, 1, 1, 0, 2'd0);
        step(1, 1, 1, 0, 2'd0);
        for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 2'd0);
        // error edge in the same cycle as the strobe
        step(1, 1, 1, 0, 2'd0);
        step(1, 1, 0, 0, 2'd0);

        // R7: inversion, alone and combined with an error
        tag = "R7";
        for (int i = 0; i < 20; i++) step(1, 1, 0, 1, 2'd0);
        step(1, 1, 1, 1, 2'd0);
        step(1, 1, 0, 1, 2'd0);

        // R6: error edge while disabled is dropped
        tag = "R6";
        step(0, 0, 0, 0, 2'd1);
        step(0, 0, 1, 0, 2'd1);
        step(0, 0, 0, 0, 2'd1);
        step(0, 1, 0, 0, 2'd1);
        step(1, 1, 0, 0, 2'd1);
        chk("R6", "no stale error", pat_bit, 1'b1);

        // R1: every select code, random strobes, inversion and errors
        for (int s = 0; s < 4; s++) begin
            tag = "R1";
            step(0, 0, 0, 0, 2'(s));
            step(0, 1, 0, 0, 2'(s));
            tag = "R3";
            for (int i = 0; i < 1500; i++)
                step(1'($urandom_range(1)), 1, ($urandom_range(15) == 0),
                     ($urandom_range(7) == 0), 2'($urandom_range(3)));
        end

        // R8/R9: periods of the two shorter sequences
        for (int s = 0; s < 2; s++) begin
            int per;
            per = (s == 0) ? 2047 : 32767;
            tag = "R8";
            step(0, 0, 0, 0, 2'(s));
            step(0, 1, 0, 0, 2'(s));
            head = '0; n = 0; ones = 0;
            for (int i = 0; i < per + 64; i++) begin
                step(1, 1, 0, 0, 2'(s));
                if (i < 64) begin
                    head[i] = pat_bit;
                    if (i >= 20 && pat_bit) ones++;
                end else if (i >= per) begin
                    chk("R8", "period repeat", pat_bit, head[i-per]);
                end
            end
            checks++;
            if (ones == 0) begin
                fails++;
                $display("FAIL R9 ones in window actual=%0d expected=nonzero", ones);
            end
        end

        tag = "R4";
        step(1, 0, 0, 0, 2'd0);
        step(1, 0, 0, 0, 2'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule